// File: doc/BRIEF.md
# Buffered single/dual-slope PWM timer

A 16-bit timer/counter that produces four pulse-width modulated outputs from one shared counter. A period value sets the highest count (TOP) and each of the four channels holds a compare value that sets its duty cycle. The timer has three modes. In normal mode the timer counts up and wraps, with the waveforms held low. In single-slope mode the timer counts up and wraps, and each output rises at TOP and falls on its compare match. In dual-slope mode the timer counts up to TOP and back down to zero, giving centre-aligned pulses.

Software writes period and compare values into shadow registers. While the timer runs, a written value waits, with a pending flag set, until the next update event. That event is at TOP in the up-counting modes and at zero in dual-slope mode, so a period never mixes two settings. While the timer is stopped, writes take effect at once. The block also gives the count value, strobes for zero and TOP, and a compare-equal strobe per channel.

Top module: `pwm_timer`

## Requirements
- R1: While reset is held, and after it is released with `run_i` low, `cnt_o` is 0, `wave_o` and `pend_o` are all zero, the active period is all ones (so `top_o` is 0) and every active compare value is 0 (so `match_o` is all ones at count 0).
- R2: In mode 0, mode 1 or mode 3 with `run_i` high, the count rises by one each clock while it is below the active period P, and returns to 0 on the clock after it equals or exceeds P.
- R3: In mode 2 with `run_i` high and P nonzero, the count steps by one from 0 up to P and then down to 0, so one period lasts 2·P clocks.
- R4: `bottom_o` is high exactly when `cnt_o` is 0. `top_o` is high exactly when `cnt_o` equals the active period. `match_o[i]` is high exactly when `cnt_o` equals the active compare value of channel i. All three follow the current count with no added delay.
- R5: A write while `run_i` is high stores the value in a shadow register and sets the matching `pend_o` bit (bit i for compare channel i, bit 4 for the period). It leaves the active value unchanged.
- R6: The update event is the running clock on which the count equals the active period (modes 0, 1, 3) or equals 0 (mode 2). On that event every pending value becomes active from the next clock, and its `pend_o` bit clears.
- R7: A write while `run_i` is low makes the value active from the next clock and leaves its `pend_o` bit at 0.
- R8: In mode 1 (single slope), with an active compare value C where 1 ≤ C < P, `wave_o[i]` is high in a clock where `cnt_o` equals k exactly when k ≤ C. The output is registered: it rises after TOP and falls after the match.
- R9: In mode 1, C = 0 keeps the output low, and C ≥ P keeps it high.
- R10: In mode 2 (dual slope), in a clock where `cnt_o` equals k, `wave_o[i]` is high when k was reached counting up and k ≤ C, or when k was reached counting down and k < C. The duty cycle is C/P.
- R11: In mode 2, C = 0 keeps the output low, and C ≥ P keeps it high.
- R12: In mode 0 and mode 3 every waveform output is low.
- R13: While `run_i` is low, the count and all waveform outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_i | input | 1 | Count enable |
| mode_i | input | 2 | 0 normal, 1 single slope, 2 dual slope, 3 treated as normal |
| per_we_i | input | 1 | Period write strobe |
| per_wdata_i | input | 16 | Period write value |
| cmp_we_i | input | 4 | Compare write strobe, one per channel |
| cmp_wdata_i | input | 16 | Compare write value shared by all channels |
| cnt_o | output | 16 | Current count |
| wave_o | output | 4 | PWM waveform per channel |
| top_o | output | 1 | Count equals active period |
| bottom_o | output | 1 | Count equals zero |
| match_o | output | 4 | Count equals channel's active compare value |
| pend_o | output | 5 | Shadow value waiting for update; bits 0..3 compare, bit 4 period |

## Verification
The waveforms are swept in single-slope, dual-slope and normal modes over periods from 1 to 8. The compare values in each sweep cover 0, values inside the period, the period itself and values above it. At every clock the bench checks the count, the strobes and each output against an arithmetic formula. This separates the rise-at-TOP rule from the rise-at-BOTTOM rule, and the counting-up match from the counting-down match. Compare and period writes made mid-period show that a value stays pending through TOP in dual-slope mode and commits only at zero, while single-slope mode commits at TOP. Writes made while the timer is stopped show immediate effect with no pending flag, and several idle cycles show that the count and outputs are frozen.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Operating mode encoding, decoded by the counter and the waveform stages
  typedef enum logic [1:0] {
    TM_NORMAL = 2'd0,
    TM_SINGLE = 2'd1,
    TM_DUAL   = 2'd2,
    TM_SPARE  = 2'd3
  } tmode_e;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         upd_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] nxt_o,
  output logic         pend_o
);

  logic [W-1:0] act_q, act_d;
  logic [W-1:0] buf_q, buf_d;
  logic         pend_q, pend_d;
  logic [W-1:0] commit_val;

  // value that becomes active at the coming edge when the timer runs
  always_comb begin
    commit_val = (upd_i && pend_q) ? buf_q : act_q;
  end

  always_comb begin
    act_d  = commit_val;
    buf_d  = buf_q;
    pend_d = pend_q;
    if (upd_i) begin
      pend_d = 1'b0;
    end
    if (we_i) begin
      buf_d = wdata_i;
      if (run_i) begin
        pend_d = 1'b1;
      end else begin
        act_d  = wdata_i;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= RST_VAL;
      buf_q  <= RST_VAL;
      pend_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      buf_q  <= buf_d;
      pend_q <= pend_d;
    end
  end

  assign act_o  = act_q;
  assign nxt_o  = commit_val;
  assign pend_o = pend_q;

  // R7
  stop_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && we_i) |=> (act_q == $past(wdata_i)) && !pend_q);

  // R5
  run_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && we_i) |=> pend_q);

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && !(we_i && !run_i)) |=> $stable(act_q));

  // R6
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && pend_q && !we_i) |=> !pend_q && (act_q == $past(buf_q)));

endmodule

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  tmode_e       mode_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] per_nxt_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o,
  output logic         top_o,
  output logic         bot_o,
  output logic         upd_o
);

  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         dir_q, dir_d;
  logic         at_top, at_bot, up_now;

  // direction of the step taken from the current count
  always_comb begin
    at_top = (cnt_q == per_i);
    at_bot = (cnt_q == '0);
    if (at_bot) begin
      up_now = 1'b1;
    end else if (cnt_q >= per_i) begin
      up_now = 1'b0;
    end else begin
      up_now = dir_q;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    case (mode_i)
      TM_DUAL: begin
        dir_d = up_now;
        if (per_nxt_i == '0) begin
          cnt_d = '0;
        end else if (up_now) begin
          cnt_d = cnt_q + STEP;
        end else begin
          cnt_d = cnt_q - STEP;
        end
      end
      default: begin
        dir_d = 1'b1;
        cnt_d = (cnt_q >= per_i) ? '0 : cnt_q + STEP;
      end
    endcase
  end

  always_comb begin
    upd_o = run_i && ((mode_i == TM_DUAL) ? at_bot : at_top);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (run_i) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_now;
  assign top_o = at_top;
  assign bot_o = at_bot;

  // R13
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i != TM_DUAL && cnt_q < per_i) |=> cnt_q == $past(cnt_q) + STEP);

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i != TM_DUAL && cnt_q >= per_i) |=> cnt_q == '0);

  // R3
  dual_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i == TM_DUAL && per_i != '0 && cnt_q == per_i) |=> cnt_q == $past(cnt_q) - STEP);

  // R3
  dual_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i == TM_DUAL && cnt_q == '0 && per_nxt_i != '0) |=> cnt_q == STEP);

endmodule

// File: rtl/pwm_wave_ch.sv
module pwm_wave_ch
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  tmode_e       mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         up_i,
  input  logic         top_i,
  input  logic         bot_i,
  output logic         wave_o
);

  logic wave_q, wave_d;
  logic hit;

  always_comb begin
    hit    = (cnt_i == cmp_i);
    wave_d = wave_q;
    case (mode_i)
      TM_SINGLE: begin
        if (top_i) begin
          wave_d = (cmp_i != '0);
        end else if (hit) begin
          wave_d = 1'b0;
        end
      end
      TM_DUAL: begin
        if (hit) begin
          wave_d = !up_i;
        end else if (bot_i) begin
          wave_d = 1'b1;
        end
      end
      default: begin
        wave_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
    end else if (run_i) begin
      wave_q <= wave_d;
    end
  end

  assign wave_o = wave_q;

  // R12
  normal_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (mode_i == TM_NORMAL || mode_i == TM_SPARE)) |=> !wave_q);

  // R13
  wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(wave_q));

  // R9
  single_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i == TM_SINGLE && top_i && cmp_i == '0) |=> !wave_q);

  // R11
  dual_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i == TM_DUAL && cmp_i == '0 && !wave_q) |=> !wave_q);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [1:0]        mode_i,
  input  logic              per_we_i,
  input  logic [CNT_W-1:0]  per_wdata_i,
  input  logic [NUM_CH-1:0] cmp_we_i,
  input  logic [CNT_W-1:0]  cmp_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [NUM_CH-1:0] wave_o,
  output logic              top_o,
  output logic              bottom_o,
  output logic [NUM_CH-1:0] match_o,
  output logic [NUM_CH:0]   pend_o
);

  localparam int PER_SLOT = NUM_CH;

  logic             rst_core_n;
  tmode_e           mode_s;
  logic [CNT_W-1:0] per_act, per_nxt;
  logic [CNT_W-1:0] cnt_s;
  logic             up_s, top_s, bot_s, upd_s;
  logic [CNT_W-1:0] cmp_act [NUM_CH];
  logic [CNT_W-1:0] cmp_nxt [NUM_CH];

  assign mode_s = tmode_e'(mode_i);

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_core_n)
  );

  pwm_shadow_reg #(.W(CNT_W), .RST_VAL({CNT_W{1'b1}})) u_per (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run_i   (run_i),
    .we_i    (per_we_i),
    .wdata_i (per_wdata_i),
    .upd_i   (upd_s),
    .act_o   (per_act),
    .nxt_o   (per_nxt),
    .pend_o  (pend_o[PER_SLOT])
  );

  pwm_cnt_core #(.W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run_i     (run_i),
    .mode_i    (mode_s),
    .per_i     (per_act),
    .per_nxt_i (per_nxt),
    .cnt_o     (cnt_s),
    .up_o      (up_s),
    .top_o     (top_s),
    .bot_o     (bot_s),
    .upd_o     (upd_s)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pwm_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .run_i   (run_i),
        .we_i    (cmp_we_i[g]),
        .wdata_i (cmp_wdata_i),
        .upd_i   (upd_s),
        .act_o   (cmp_act[g]),
        .nxt_o   (cmp_nxt[g]),
        .pend_o  (pend_o[g])
      );

      pwm_wave_ch #(.W(CNT_W)) u_wave (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .run_i  (run_i),
        .mode_i (mode_s),
        .cnt_i  (cnt_s),
        .cmp_i  (cmp_nxt[g]),
        .up_i   (up_s),
        .top_i  (top_s),
        .bot_i  (bot_s),
        .wave_o (wave_o[g])
      );

      assign match_o[g] = (cnt_s == cmp_act[g]);
    end
  endgenerate

  assign cnt_o    = cnt_s;
  assign top_o    = top_s;
  assign bottom_o = bot_s;

endmodule

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;

  logic        clk;
  logic        rst_n;
  logic        run_i;
  logic [1:0]  mode_i;
  logic        per_we_i;
  logic [15:0] per_wdata_i;
  logic [3:0]  cmp_we_i;
  logic [15:0] cmp_wdata_i;
  logic [15:0] cnt_o;
  logic [3:0]  wave_o;
  logic        top_o;
  logic        bottom_o;
  logic [3:0]  match_o;
  logic [4:0]  pend_o;

  int tests = 0;
  int fails = 0;

  pwm_timer u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .mode_i      (mode_i),
    .per_we_i    (per_we_i),
    .per_wdata_i (per_wdata_i),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .cnt_o       (cnt_o),
    .wave_o      (wave_o),
    .top_o       (top_o),
    .bottom_o    (bottom_o),
    .match_o     (match_o),
    .pend_o      (pend_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put_per(input int v);
    per_we_i    = 1'b1;
    per_wdata_i = 16'(v);
    @(negedge clk);
    per_we_i    = 1'b0;
  endtask

  task automatic put_cmp(input int ch, input int v);
    cmp_we_i     = 4'b0;
    cmp_we_i[ch] = 1'b1;
    cmp_wdata_i  = 16'(v);
    @(negedge clk);
    cmp_we_i     = 4'b0;
  endtask

  task automatic wait_cnt(input int v);
    for (int n = 0; n < 1000 && int'(cnt_o) != v; n++) @(negedge clk);
    chk(int'(cnt_o) == v, "R2 reach count", cnt_o, v);
  endtask

  // sweep one mode/period/compare set; expected values computed from R2..R4, R8..R12
  task automatic sweep(input int md, input int p, input int base);
    int c [4];
    int prev, k, e;
    bit dir_up, w_exp;
    string tg;
    for (int i = 0; i < 4; i++) c[i] = base + i;
    run_i = 1'b0;
    @(negedge clk);
    put_per(p);
    for (int i = 0; i < 4; i++) put_cmp(i, c[i]);
    mode_i = 2'(md);
    run_i  = 1'b1;
    repeat (4 * p + 24) @(negedge clk);
    prev = int'(cnt_o);
    @(negedge clk);
    dir_up = int'(cnt_o) > prev;
    prev   = int'(cnt_o);
    for (int n = 0; n < 4 * p + 4; n++) begin
      @(negedge clk);
      k = int'(cnt_o);
      if (md == 2) begin
        if (prev == 0) e = 1;
        else if (prev >= p) e = prev - 1;
        else e = dir_up ? prev + 1 : prev - 1;
        chk(k == e, "R3 dual count", k, e);
      end else begin
        e = (prev >= p) ? 0 : prev + 1;
        chk(k == e, "R2 up count", k, e);
      end
      chk(bottom_o == (k == 0), "R4 bottom", bottom_o, k == 0);
      chk(top_o == (k == p), "R4 top", top_o, k == p);
      for (int i = 0; i < 4; i++) begin
        chk(match_o[i] == (k == c[i]), "R4 match", match_o[i], k == c[i]);
        if (md == 1) begin
          w_exp = (c[i] != 0) && (k <= c[i]);
          tg = (c[i] == 0 || c[i] >= p) ? "R9 single edge" : "R8 single wave";
        end else if (md == 2) begin
          w_exp = (k > prev) ? (k <= c[i]) : (k < c[i]);
          tg = (c[i] == 0 || c[i] >= p) ? "R11 dual edge" : "R10 dual wave";
        end else begin
          w_exp = 1'b0;
          tg = "R12 normal low";
        end
        chk(wave_o[i] == w_exp, tg, wave_o[i], w_exp);
      end
      dir_up = k > prev;
      prev   = k;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s;
    logic [3:0] w;
    rst_n       = 1'b0;
    run_i       = 1'b0;
    mode_i      = 2'd0;
    per_we_i    = 1'b0;
    per_wdata_i = '0;
    cmp_we_i    = '0;
    cmp_wdata_i = '0;

    // R1 during and after reset
    repeat (3) @(negedge clk);
    chk(cnt_o == 0, "R1 count in reset", cnt_o, 0);
    chk(wave_o == 0, "R1 wave in reset", wave_o, 0);
    chk(pend_o == 0, "R1 pending in reset", pend_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cnt_o == 0, "R1 count after reset", cnt_o, 0);
    chk(top_o == 0, "R1 period all ones", top_o, 0);
    chk(bottom_o == 1, "R1 bottom", bottom_o, 1);
    chk(match_o == 4'hF, "R1 compare zero", match_o, 15);
    chk(pend_o == 0, "R1 pending", pend_o, 0);

    // sweeps: R2 R3 R4 R8 R9 R10 R11 R12
    foreach (s_list[j]) begin
      for (int b = 0; b <= s_list[j] + 1; b += 4) sweep(1, s_list[j], b);
    end
    foreach (s_list[j]) begin
      for (int b = 0; b <= s_list[j] + 1; b += 4) sweep(2, s_list[j], b);
    end
    sweep(0, 4, 0);
    sweep(3, 3, 1);

    // R5 R6 single slope: compare committed at TOP
    run_i = 1'b0;
    @(negedge clk);
    put_per(9);
    put_cmp(0, 2);
    mode_i = 2'd1;
    run_i  = 1'b1;
    wait_cnt(3);
    put_cmp(0, 6);
    chk(pend_o[0] == 1, "R5 pending set", pend_o[0], 1);
    wait_cnt(6);
    chk(match_o[0] == 0, "R5 old compare kept", match_o[0], 0);
    wait_cnt(9);
    chk(pend_o[0] == 1, "R6 pending until top", pend_o[0], 1);
    @(negedge clk);
    chk(pend_o[0] == 0, "R6 commit at top", pend_o[0], 0);
    wait_cnt(2);
    chk(match_o[0] == 0, "R6 old compare gone", match_o[0], 0);
    wait_cnt(6);
    chk(match_o[0] == 1, "R6 new compare", match_o[0], 1);

    // R5 R6 dual slope: compare committed at BOTTOM, not at TOP
    run_i = 1'b0;
    @(negedge clk);
    put_per(9);
    put_cmp(1, 2);
    mode_i = 2'd2;
    run_i  = 1'b1;
    wait_cnt(0);
    wait_cnt(3);
    put_cmp(1, 7);
    chk(pend_o[1] == 1, "R5 dual pending", pend_o[1], 1);
    wait_cnt(9);
    chk(pend_o[1] == 1, "R6 no commit at top in dual", pend_o[1], 1);
    wait_cnt(0);
    chk(pend_o[1] == 1, "R6 pending at bottom", pend_o[1], 1);
    @(negedge clk);
    chk(cnt_o == 1, "R3 rise after bottom", cnt_o, 1);
    chk(pend_o[1] == 0, "R6 commit at bottom", pend_o[1], 0);
    wait_cnt(7);
    chk(match_o[1] == 1, "R6 dual new compare", match_o[1], 1);

    // R5 R6 period buffering
    run_i = 1'b0;
    @(negedge clk);
    put_per(9);
    mode_i = 2'd1;
    run_i  = 1'b1;
    wait_cnt(3);
    put_per(5);
    chk(pend_o[4] == 1, "R5 period pending", pend_o[4], 1);
    wait_cnt(9);
    chk(top_o == 1, "R5 old period kept", top_o, 1);
    @(negedge clk);
    chk(cnt_o == 0, "R6 wrap at old period", cnt_o, 0);
    chk(pend_o[4] == 0, "R6 period committed", pend_o[4], 0);
    wait_cnt(5);
    chk(top_o == 1, "R6 new period top", top_o, 1);
    @(negedge clk);
    chk(cnt_o == 0, "R6 wrap at new period", cnt_o, 0);

    // R7 R13 stopped timer
    wait_cnt(3);
    run_i = 1'b0;
    @(negedge clk);
    s = int'(cnt_o);
    w = wave_o;
    put_cmp(2, s);
    chk(match_o[2] == 1, "R7 immediate compare", match_o[2], 1);
    chk(pend_o[2] == 0, "R7 no pending", pend_o[2], 0);
    put_per(s);
    chk(top_o == 1, "R7 immediate period", top_o, 1);
    chk(pend_o[4] == 0, "R7 period no pending", pend_o[4], 0);
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      chk(int'(cnt_o) == s, "R13 count frozen", cnt_o, s);
      chk(wave_o == w, "R13 wave frozen", wave_o, w);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int s_list [5] = '{1, 2, 3, 5, 8};

endmodule